// File: doc/BRIEF.md
# Posit Word Decoder

This unit unpacks a posit-format word into fields that a conventional floating-point datapath can consume. A posit word holds a sign bit, then a regime field coded as a run of equal bits, then up to `ES` exponent bits, then fraction bits. The regime is variable-length, so the position of the exponent and fraction moves from word to word. The decoder measures the regime run with leading-ones and leading-zeros counters. It shifts the remaining bits up by that run. It then reports a sign, one signed binary scale that combines regime and exponent, and a left-aligned mantissa with the hidden one made explicit. Two flags mark the zero code and the infinity code.

A word is presented with a qualifying valid bit. One clock edge later the decoded bundle appears on registered outputs together with a delayed valid. The outputs keep their last value while no new word is offered. The word width `N` and the exponent width `ES` are parameters. The unit is meant for (8,1), (16,1) and (16,2) and for any other width with `N >= 5` and `1 <= ES <= N-3`.

Top module: `posit_unpack`

## Requirements
- R1: `out_sign` equals bit `N-1` of the accepted word. For a word with that bit set, regime, exponent and fraction are taken from the two's complement of the lower `N-1` bits, so the decoded magnitude is that of the negated word.
- R2: In the lower `N-1` bits, counted from bit `N-2` downward, a run of m ones followed by a zero (or by the end of the word) gives regime value k = m-1. A run of m zeros followed by a one gives k = -m.
- R3: The `ES` bits after the regime's terminating bit form the exponent e, with the most significant bit first. Positions past the end of the word read as zero. `out_scale` is the two's complement value k·2^ES + e.
- R4: For a normal word, `out_mant` bit `N-2` (the hidden one) is 1. Bits `N-3` down to 0 hold the fraction bits that follow the exponent, left-aligned and zero-filled. With no fraction bits left, they are all zero.
- R5: The all-zero word sets `out_zero` and clears `out_inf` and `out_sign`, and it gives `out_scale` = 0 and `out_mant` = 0.
- R6: The word with only bit `N-1` set sets `out_inf` and `out_sign` and clears `out_zero`, and it gives `out_scale` = 0 and `out_mant` = 0.
- R7: `out_valid` is `in_valid` delayed by one clock edge, and the decoded fields for a word accepted at an edge appear at that same edge.
- R8: While `in_valid` is low, every data output and flag keeps its value, whatever `in_word` carries.
- R9: Reset is synchronous and active high. It clears `out_valid`, both flags, `out_sign`, `out_scale` and `out_mant`.
- R10: `out_scale` stays within ±(N-2)·2^ES. The largest positive word (0 then all ones) gives +(N-2)·2^ES, and the smallest positive word (only bit 0 set) gives -(N-2)·2^ES.
- R11: For any word other than infinity, the real number (-1)^sign · 2^scale · mant / 2^(N-2) equals the posit's value (-1)^s · useed^k · 2^e · (1+f), where useed = 2^(2^ES).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_word` for this cycle |
| in_word | input | N | Posit word to decode |
| out_valid | output | 1 | Decoded bundle updated at the last edge |
| out_sign | output | 1 | Sign of the decoded word |
| out_zero | output | 1 | Word was the zero code |
| out_inf | output | 1 | Word was the infinity code |
| out_scale | output | scale_w(N,ES) | Signed binary scale k·2^ES + e |
| out_mant | output | N-1 | Hidden one followed by the left-aligned fraction |

## Verification
A wrong run count or a shifter off by one position moves the exponent and fraction, so `out_scale` and `out_mant` are wrong one edge after the word is accepted. The exhaustive 8-bit sweep reaches every regime length, and with it every shift amount, so such a fault shows on the first word that uses the bad amount. A missed negation shows only on words with the sign set, and the real-value comparison catches it in the same cycle. A fault in the hold or valid registers shows on the first idle cycle after a decoded word.

// File: rtl/posit_pkg.sv
package posit_pkg;

    // Classification of an incoming word
    typedef enum logic [1:0] {
        CLS_NORMAL = 2'd0,
        CLS_ZERO   = 2'd1,
        CLS_INF    = 2'd2
    } word_class_e;

    // Width of a counter that can hold a run of up to n-1 bits
    function automatic int cnt_w(input int n);
        return $clog2(n);
    endfunction

    // Signed width that holds +/-(n-2)*2^es
    function automatic int scale_w(input int n, input int es);
        return $clog2(((n - 2) << es) + 1) + 1;
    endfunction

    // Magnitude limit of the decoded scale
    function automatic int scale_lim(input int n, input int es);
        return (n - 2) << es;
    endfunction

endpackage

// File: rtl/posit_lead_run.sv
// Counts how many bits, starting at the MSB, equal MATCH.
module posit_lead_run #(
    parameter int   W     = 15,
    parameter int   CW    = 4,
    parameter logic MATCH = 1'b1
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] run
);
    logic still;

    always_comb begin
        run   = '0;
        still = 1'b1;
        for (int i = W - 1; i >= 0; i--) begin
            if (still && (vec[i] == MATCH)) begin
                run = run + CW'(1);
            end else begin
                still = 1'b0;
            end
        end
    end
endmodule

// File: rtl/posit_shl.sv
// Logarithmic left barrel shifter, zero fill.
module posit_shl #(
    parameter int W  = 14,
    parameter int CW = 4
) (
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stg [0:CW];

    assign stg[0] = din;

    for (genvar j = 0; j < CW; j++) begin : g_stage
        assign stg[j+1] = amt[j] ? (stg[j] << (1 << j)) : stg[j];
    end

    assign dout = stg[CW];
endmodule

// File: rtl/posit_unpack.sv
module posit_unpack
    import posit_pkg::*;
#(
    parameter int N  = 16,
    parameter int ES = 1
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 in_valid,
    input  logic [N-1:0]                         in_word,
    output logic                                 out_valid,
    output logic                                 out_sign,
    output logic                                 out_zero,
    output logic                                 out_inf,
    output logic signed [scale_w(N, ES)-1:0]     out_scale,
    output logic [N-2:0]                         out_mant
);
    localparam int BW = N - 1;           // body after the sign
    localparam int PW = N - 2;           // bits after the first regime bit
    localparam int MW = N - 1;           // hidden one + fraction
    localparam int CW = cnt_w(N);
    localparam int SW = scale_w(N, ES);

    typedef struct packed {
        logic                 sign;
        word_class_e          cls;
        logic signed [SW-1:0] scale;
        logic [MW-1:0]        mant;
    } dec_t;

    logic [BW-1:0]        body;
    logic [CW-1:0]        ones_run;
    logic [CW-1:0]        zeros_run;
    logic [PW-1:0]        sh_pos;
    logic [PW-1:0]        sh_neg;
    logic [PW-1:0]        payload;
    logic [ES-1:0]        exp_bits;
    logic [PW-1:0]        frac_al;
    logic signed [SW-1:0] k_val;
    dec_t                 dec_c;
    dec_t                 dec_q;
    logic                 vld_q;

    // Fold negative words onto their magnitude
    assign body = in_word[N-1] ? (-in_word[BW-1:0]) : in_word[BW-1:0];

    // Two run detectors, one per regime polarity
    posit_lead_run #(.W(BW), .CW(CW), .MATCH(1'b1)) u_run_ones (
        .vec (body),
        .run (ones_run)
    );

    posit_lead_run #(.W(BW), .CW(CW), .MATCH(1'b0)) u_run_zeros (
        .vec (body),
        .run (zeros_run)
    );

    // Duplicated shifters: each is fed straight from its own counter,
    // the polarity select sits after the shift.
    posit_shl #(.W(PW), .CW(CW)) u_shl_pos (
        .din  (body[BW-2:0]),
        .amt  (ones_run),
        .dout (sh_pos)
    );

    posit_shl #(.W(PW), .CW(CW)) u_shl_neg (
        .din  (body[BW-2:0]),
        .amt  (zeros_run),
        .dout (sh_neg)
    );

    assign payload  = body[BW-1] ? sh_pos : sh_neg;
    assign exp_bits = payload[PW-1 -: ES];
    assign frac_al  = payload << ES;

    always_comb begin
        if (body[BW-1]) begin
            k_val = $signed(SW'(ones_run)) - $signed(SW'(1));
        end else begin
            k_val = -$signed(SW'(zeros_run));
        end
    end

    always_comb begin
        dec_c.sign  = in_word[N-1];
        dec_c.scale = (k_val <<< ES) + $signed(SW'(exp_bits));
        dec_c.mant  = {1'b1, frac_al};
        dec_c.cls   = CLS_NORMAL;
        if (in_word == '0) begin
            dec_c.cls = CLS_ZERO;
        end else if (in_word == {1'b1, {BW{1'b0}}}) begin
            dec_c.cls = CLS_INF;
        end
        if (dec_c.cls != CLS_NORMAL) begin
            dec_c.scale = '0;
            dec_c.mant  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            dec_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                dec_q <= dec_c;
            end
        end
    end

    assign out_valid = vld_q;
    assign out_sign  = dec_q.sign;
    assign out_zero  = (dec_q.cls == CLS_ZERO);
    assign out_inf   = (dec_q.cls == CLS_INF);
    assign out_scale = dec_q.scale;
    assign out_mant  = dec_q.mant;
endmodule

// File: rtl/posit_unpack_chk.sv
module posit_unpack_chk
    import posit_pkg::*;
#(
    parameter int N  = 16,
    parameter int ES = 1
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             in_valid,
    input logic [N-1:0]                     in_word,
    input logic                             out_valid,
    input logic                             out_sign,
    input logic                             out_zero,
    input logic                             out_inf,
    input logic signed [scale_w(N, ES)-1:0] out_scale,
    input logic [N-2:0]                     out_mant
);
    localparam int SW  = scale_w(N, ES);
    localparam int LIM = scale_lim(N, ES);
    localparam logic signed [SW-1:0] LIM_P = SW'(LIM);
    localparam logic signed [SW-1:0] LIM_N = -SW'(LIM);

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                      // R7

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                    // R7

    AST_SIGN_PASS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_sign == $past(in_word[N-1])));              // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_sign) && $stable(out_zero) && $stable(out_inf)
                       && $stable(out_scale) && $stable(out_mant))); // R8

    AST_ZERO_CODE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word == '0) |=>
        (out_zero && !out_inf && !out_sign && out_scale == '0 && out_mant == '0)); // R5

    AST_INF_CODE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word == {1'b1, {(N-1){1'b0}}}) |=>
        (out_inf && !out_zero && out_sign && out_scale == '0 && out_mant == '0)); // R6

    AST_HIDDEN_ONE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_zero && !out_inf) |-> out_mant[N-2]);      // R4

    AST_SCALE_BOUND: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_scale <= LIM_P && out_scale >= LIM_N));    // R10

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_zero && !out_inf && !out_sign
                 && out_scale == '0 && out_mant == '0));              // R9
endmodule

bind posit_unpack posit_unpack_chk #(.N(N), .ES(ES)) u_posit_unpack_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_sign  (out_sign),
    .out_zero  (out_zero),
    .out_inf   (out_inf),
    .out_scale (out_scale),
    .out_mant  (out_mant)
);

// File: tb/test_posit_unpack.sv
module test_posit_unpack;
    import posit_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_WORDS = 1500;

    localparam int SWA = scale_w(8, 1);
    localparam int SWB = scale_w(16, 2);
    localparam int SWC = scale_w(16, 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   tests  = 0;
    int   failed = 0;
    bit   done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // (8,1) under exhaustive sweep
    logic                  a_v = 1'b0;
    logic [7:0]            a_w = '0;
    logic                  a_ov, a_os, a_oz, a_oi;
    logic signed [SWA-1:0] a_sc;
    logic [6:0]            a_m;
    // (16,2) random
    logic                  b_v = 1'b0;
    logic [15:0]           b_w = '0;
    logic                  b_ov, b_os, b_oz, b_oi;
    logic signed [SWB-1:0] b_sc;
    logic [14:0]           b_m;
    // (16,1) random
    logic                  c_v = 1'b0;
    logic [15:0]           c_w = '0;
    logic                  c_ov, c_os, c_oz, c_oi;
    logic signed [SWC-1:0] c_sc;
    logic [14:0]           c_m;

    posit_unpack #(.N(8), .ES(1)) i_posit_unpack (
        .clk(clk), .rst(rst), .in_valid(a_v), .in_word(a_w),
        .out_valid(a_ov), .out_sign(a_os), .out_zero(a_oz), .out_inf(a_oi),
        .out_scale(a_sc), .out_mant(a_m));

    posit_unpack #(.N(16), .ES(2)) i_posit_unpack_16e2 (
        .clk(clk), .rst(rst), .in_valid(b_v), .in_word(b_w),
        .out_valid(b_ov), .out_sign(b_os), .out_zero(b_oz), .out_inf(b_oi),
        .out_scale(b_sc), .out_mant(b_m));

    posit_unpack #(.N(16), .ES(1)) i_posit_unpack_16e1 (
        .clk(clk), .rst(rst), .in_valid(c_v), .in_word(c_w),
        .out_valid(c_ov), .out_sign(c_os), .out_zero(c_oz), .out_inf(c_oi),
        .out_scale(c_sc), .out_mant(c_m));

    // Bit-serial reference decode, walking the word one position at a time
    task automatic ref_decode(input int n, input int es, input longint w,
                              output bit s, output bit z, output bit inf,
                              output int scale, output longint mant,
                              output real val);
        longint mask = (64'd1 << (n - 1)) - 1;
        longint body;
        longint fb = 0;
        int lead, m, pos, k, e, nf, b;
        s = bit'((w >> (n - 1)) & 1);
        z = (w == 0);
        inf = (w == (64'd1 << (n - 1)));
        scale = 0; mant = 0; val = 0.0;
        if (!z && !inf) begin
            body = s ? ((-w) & mask) : (w & mask);
            lead = int'((body >> (n - 2)) & 1);
            m = 0;
            pos = n - 2;
            while (pos >= 0 && int'((body >> pos) & 1) == lead) begin
                m++;
                pos--;
            end
            pos--;
            k = lead ? m - 1 : -m;
            e = 0;
            for (int j = 0; j < es; j++) begin
                e = e * 2 + ((pos >= 0) ? int'((body >> pos) & 1) : 0);
                pos--;
            end
            nf = 0;
            mant = 1;
            for (int j = 0; j < n - 2; j++) begin
                b = (pos >= 0) ? int'((body >> pos) & 1) : 0;
                if (pos >= 0) begin
                    fb = fb * 2 + b;
                    nf++;
                end
                mant = mant * 2 + b;
                pos--;
            end
            scale = k * (1 << es) + e;
            val = (s ? -1.0 : 1.0) * (2.0 ** (k * (1 << es))) * (2.0 ** e)
                  * (1.0 + real'(fb) / (2.0 ** nf));
        end
    endtask

    task automatic check_out(input string cfg, input int n, input int es,
                             input longint w, input bit exp_v,
                             input bit ov, input bit os, input bit oz, input bit oi,
                             input int osc, input longint om);
        bit s, z, inf;
        int sc;
        longint mt;
        real v, dv;
        ref_decode(n, es, w, s, z, inf, sc, mt, v);
        dv = (os ? -1.0 : 1.0) * (2.0 ** osc) * real'(om) / (2.0 ** (n - 2));
        tests++;
        if (ov != exp_v) begin
            failed++;
            $display("FAIL R7 %s word %h: out_valid=%0d expected %0d", cfg, w, ov, exp_v);
        end else if (os != s) begin
            failed++;
            $display("FAIL R1 %s word %h: sign=%0d expected %0d", cfg, w, os, s);
        end else if (oz != z) begin
            failed++;
            $display("FAIL R5 %s word %h: zero=%0d expected %0d", cfg, w, oz, z);
        end else if (oi != inf) begin
            failed++;
            $display("FAIL R6 %s word %h: inf=%0d expected %0d", cfg, w, oi, inf);
        end else if (osc != sc) begin
            failed++;
            $display("FAIL R2 R3 %s word %h: scale=%0d expected %0d", cfg, w, osc, sc);
        end else if (om != mt) begin
            failed++;
            $display("FAIL R4 %s word %h: mant=%h expected %h", cfg, w, om, mt);
        end else if (!inf && dv != v) begin
            failed++;
            $display("FAIL R11 %s word %h: value=%g expected %g", cfg, w, dv, v);
        end
    endtask

    task automatic check_int(input string req, input int act, input int expv);
        tests++;
        if (act != expv) begin
            failed++;
            $display("FAIL %s: got %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic check_all(input bit exp_v, input longint wa, input longint wb,
                             input longint wc);
        check_out("p8e1",  8, 1, wa, exp_v, a_ov, a_os, a_oz, a_oi, int'(a_sc), longint'(a_m));
        check_out("p16e2", 16, 2, wb, exp_v, b_ov, b_os, b_oz, b_oi, int'(b_sc), longint'(b_m));
        check_out("p16e1", 16, 1, wc, exp_v, c_ov, c_os, c_oz, c_oi, int'(c_sc), longint'(c_m));
    endtask

    function automatic logic [15:0] pick16(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h8000;
            2: return 16'h7FFF;
            3: return 16'h0001;
            4: return 16'hFFFF;
            5: return 16'h8001;
            6: return 16'h4000;
            7: return 16'hC000;
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        logic [15:0] wb, wc, hb, hc;
        logic [7:0]  wa, ha;
        // Reset state (R9)
        repeat (3) @(negedge clk);
        check_int("R9 p8e1 out_valid", int'(a_ov), 0);
        check_int("R9 p8e1 flags", int'(a_oz) + int'(a_oi) + int'(a_os), 0);
        check_int("R9 p8e1 scale", int'(a_sc), 0);
        check_int("R9 p8e1 mant", int'(a_m), 0);
        check_int("R9 p16e2 mant", int'(b_m), 0);
        rst = 1'b0;

        // Exhaustive (8,1), random (16,2) and (16,1)
        for (int i = 0; i < RAND_WORDS; i++) begin
            wa = 8'(i);
            wb = pick16(i);
            wc = pick16(i);
            @(negedge clk);
            a_v = 1'b1; a_w = wa;
            b_v = 1'b1; b_w = wb;
            c_v = 1'b1; c_w = wc;
            @(negedge clk);
            check_all(1'b1, longint'(wa), longint'(wb), longint'(wc));
        end

        // Scale extremes (R10)
        @(negedge clk);
        a_w = 8'h7F; b_w = 16'h7FFF; c_w = 16'h0001;
        @(negedge clk);
        check_int("R10 p8e1 max scale", int'(a_sc), 12);
        check_int("R10 p16e2 max scale", int'(b_sc), 56);
        check_int("R10 p16e1 min scale", int'(c_sc), -28);
        a_w = 8'h01;
        @(negedge clk);
        check_int("R10 p8e1 min scale", int'(a_sc), -12);

        // Hold while idle (R8): decode a word, then drop valid and change the input
        ha = 8'hB5; hb = 16'h3A7C; hc = 16'hE123;
        a_w = ha; b_w = hb; c_w = hc;
        @(negedge clk);
        check_all(1'b1, longint'(ha), longint'(hb), longint'(hc));
        a_v = 1'b0; b_v = 1'b0; c_v = 1'b0;
        a_w = 8'h00; b_w = 16'h8000; c_w = 16'h7FFF;
        for (int r = 0; r < 3; r++) begin
            @(negedge clk);
            check_all(1'b0, longint'(ha), longint'(hb), longint'(hc)); // R8
        end

        // Valid resumes for one word (R7)
        a_v = 1'b1; a_w = 8'h40;
        @(negedge clk);
        a_v = 1'b0;
        check_out("p8e1", 8, 1, 64'h40, 1'b1, a_ov, a_os, a_oz, a_oi, int'(a_sc), longint'(a_m));
        @(negedge clk);
        check_int("R7 p8e1 valid falls", int'(a_ov), 0);

        $display("[TB] %0d tests run, %0d failed", tests, failed);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end
endmodule